// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block sits on a device that fetches its own configuration from an external serial memory. After system reset, after an abort, or when the done line is pulled low by another agent, it samples three mode inputs. If all three are low it becomes the clock master for the load. It drives a configuration clock at one quarter of the system clock and takes one bit from the serial data line on every rising edge of that clock. When any mode input is high it stays quiet and waits for the next reconfiguration request.

The stream it expects has a fixed layout. First comes any run of filler bits, normally ones. An 8-bit sync pattern 0xF2 follows, then a 24-bit bit count, then exactly that many payload bits. All fields arrive most significant bit first. Payload bits are gathered into parallel words and each word is presented with a one-cycle valid strobe. When the count is satisfied the loader stops the clock and raises done.

If the sync pattern has not appeared within 64 sampled bits, the loader stops the clock and raises an error flag. An abort input throws away any load in progress at once and starts a new one from the mode check. Writing into the configured fabric is not part of this block.

Top module: `cfg_serial_loader`

## Requirements
- R1: While `rst` is high and in the cycle after it, `done_o`, `load_err_o`, `frame_valid_o` and `cfg_clk_o` are all 0. The first load starts when `rst` is released.
- R2: A load starts only if `mode_i` equals 3'b000 at the start decision. For any other value `cfg_clk_o` produces no rising edge and `done_o` stays 0 until the next `done_pull_i` pulse.
- R3: While loading, `cfg_clk_o` is high for 2 and low for 2 system cycles, so consecutive rising edges are exactly 4 cycles apart. `ser_din_i` is captured at the system clock edge on which `cfg_clk_o` rises.
- R4: Sampled bits are discarded until the last 8 bits, oldest first, equal 8'hF2. Filler that does not complete the pattern, including zeros, is ignored.
- R5: The 24 bits after the sync pattern, MSB first, give the payload length L. The total number of `cfg_clk_o` rising edges in a load is (bits up to and including the sync pattern) + 24 + L, and no further edge follows.
- R6: Payload bits are packed MSB first into words of FRAME_W (8) bits. Each word is output on `frame_data_o` with `frame_valid_o` high for exactly one cycle. A final partial word holds its bits right-justified with zeros above, giving ceil(L/8) words in total.
- R7: `done_o` rises right after the last payload bit is captured, or right after the length field when L is 0. It stays high until `done_pull_i` or `abort_i`.
- R8: A one-cycle `abort_i` pulse during a load ends that load. No further bit of it is taken, no partly filled word is emitted, and a complete new load follows.
- R9: A `done_pull_i` pulse while done is high lowers `done_o` on the next cycle and starts a new load, with the mode inputs sampled again.
- R10: If 64 bits are sampled without the sync pattern completing, `load_err_o` goes high, the clock stops after exactly 64 rising edges, and `done_o` stays 0. `load_err_o` is never high together with `done_o`. A later `done_pull_i` clears the flag and starts a new load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; releasing it starts a load |
| mode_i | input | 3 | Mode select; 3'b000 selects the serial master load |
| abort_i | input | 1 | External reset: abort the current load and restart |
| done_pull_i | input | 1 | Done line pulled low externally: request reconfiguration |
| ser_din_i | input | 1 | Serial data from the external memory |
| cfg_clk_o | output | 1 | Configuration clock driven to the memory |
| done_o | output | 1 | Load complete |
| load_err_o | output | 1 | Sync pattern not found in time |
| frame_data_o | output | FRAME_W | Assembled payload word |
| frame_valid_o | output | 1 | One-cycle strobe for `frame_data_o` |

## Verification
The hardest case to reach is an abort that lands while a payload word is half built and a clock phase is mid-way. The bench waits until its memory model has handed out a chosen number of bits inside the payload, pulses the abort at that point, and rewinds the memory model. It then requires a clean full load with the exact edge count and no leftover word. The 64-bit sync window is approached from both sides: with 56 filler ones the pattern completes on the 64th bit, and with 57 it misses. Payload lengths are swept from 0 through 20 so that every partial-word remainder is covered.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        LD_START = 3'd0,
        LD_OFF   = 3'd1,
        LD_HUNT  = 3'd2,
        LD_LEN   = 3'd3,
        LD_DATA  = 3'd4,
        LD_DONE  = 3'd5,
        LD_ERR   = 3'd6
    } ld_state_e;

    localparam logic [2:0] MASTER_SERIAL_MODE = 3'b000;

    function automatic logic st_is_loading(ld_state_e st);
        return (st == LD_HUNT) || (st == LD_LEN) || (st == LD_DATA);
    endfunction

    function automatic logic st_is_parked(ld_state_e st);
        return (st == LD_OFF) || (st == LD_DONE) || (st == LD_ERR);
    endfunction

endpackage

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic kill_i,
    output logic cfg_clk_o,
    output logic sample_o
);
    localparam int HALF = 1 << (DIV_LOG2 - 1);

    logic [DIV_LOG2-1:0] div_q;

    // Phase counter runs while loading and always finishes a started period.
    always_ff @(posedge clk) begin
        if (rst || kill_i) begin
            div_q <= '0;
        end else if (run_i || (div_q != '0)) begin
            div_q <= div_q + 1'b1;
        end
    end

    assign cfg_clk_o = div_q[DIV_LOG2-1];
    assign sample_o  = run_i && !kill_i && (div_q == DIV_LOG2'(HALF - 1));

endmodule

// File: rtl/cfg_header_parser.sv
module cfg_header_parser #(
    parameter int          PRE_W      = 8,
    parameter logic [7:0]  PREAMBLE   = 8'hF2,
    parameter int          LEN_W      = 24,
    parameter int          HUNT_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             sample_i,
    input  logic             bit_i,
    input  logic             hunt_i,
    input  logic             len_i,
    output logic             pre_hit_o,
    output logic             hunt_exp_o,
    output logic             len_done_o,
    output logic             len_zero_o,
    output logic [LEN_W-1:0] len_val_o
);
    localparam int HC_W = $clog2(HUNT_LIMIT + 1);
    localparam int LC_W = $clog2(LEN_W + 1);

    logic [PRE_W-1:0] win_q;
    logic [PRE_W-1:0] win_next;
    logic [HC_W-1:0]  hunt_cnt_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_next;
    logic [LC_W-1:0]  len_cnt_q;
    logic             take_hunt;
    logic             take_len;

    assign take_hunt = sample_i && hunt_i;
    assign take_len  = sample_i && len_i;
    assign win_next  = {win_q[PRE_W-2:0], bit_i};
    assign len_next  = {len_q[LEN_W-2:0], bit_i};

    assign pre_hit_o  = take_hunt && (win_next == PREAMBLE[PRE_W-1:0]);
    assign hunt_exp_o = take_hunt && !pre_hit_o &&
                        (hunt_cnt_q == HC_W'(HUNT_LIMIT - 1));
    assign len_done_o = take_len && (len_cnt_q == LC_W'(LEN_W - 1));
    assign len_zero_o = (len_next == '0);
    assign len_val_o  = len_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            win_q      <= '0;
            hunt_cnt_q <= '0;
            len_q      <= '0;
            len_cnt_q  <= '0;
        end else begin
            if (take_hunt) begin
                win_q      <= win_next;
                hunt_cnt_q <= hunt_cnt_q + 1'b1;
            end
            if (take_len) begin
                len_q     <= len_next;
                len_cnt_q <= len_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_frame_packer.sv
module cfg_frame_packer #(
    parameter int FRAME_W = 8,
    parameter int LEN_W   = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_i,
    input  logic               sample_i,
    input  logic               bit_i,
    input  logic [LEN_W-1:0]   total_i,
    output logic               last_o,
    output logic [FRAME_W-1:0] frame_data_o,
    output logic               frame_valid_o
);
    localparam int FC_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;

    logic [LEN_W-1:0]   bit_cnt_q;
    logic [FRAME_W-1:0] frm_q;
    logic [FRAME_W-1:0] frm_next;
    logic [FC_W-1:0]    frm_cnt_q;
    logic               flush;

    assign frm_next = {frm_q[FRAME_W-2:0], bit_i};
    assign last_o   = sample_i &&
                      (({1'b0, bit_cnt_q} + 1'b1) == {1'b0, total_i});
    assign flush    = sample_i &&
                      ((frm_cnt_q == FC_W'(FRAME_W - 1)) || last_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_data_o <= '0;
        end else if (flush) begin
            frame_data_o <= frm_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            bit_cnt_q     <= '0;
            frm_q         <= '0;
            frm_cnt_q     <= '0;
            frame_valid_o <= 1'b0;
        end else begin
            frame_valid_o <= flush;
            if (sample_i) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (flush) begin
                    frm_q     <= '0;
                    frm_cnt_q <= '0;
                end else begin
                    frm_q     <= frm_next;
                    frm_cnt_q <= frm_cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int         FRAME_W    = 8,
    parameter int         LEN_W      = 24,
    parameter int         HUNT_LIMIT = 64,
    parameter int         DIV_LOG2   = 2,
    parameter logic [7:0] PREAMBLE   = 8'hF2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         mode_i,
    input  logic               abort_i,
    input  logic               done_pull_i,
    input  logic               ser_din_i,
    output logic               cfg_clk_o,
    output logic               done_o,
    output logic               load_err_o,
    output logic [FRAME_W-1:0] frame_data_o,
    output logic               frame_valid_o
);
    localparam int PRE_W = 8;

    ld_state_e        st_q;
    ld_state_e        st_next;
    logic             loading;
    logic             clr;
    logic             sample;
    logic             pre_hit;
    logic             hunt_exp;
    logic             len_done;
    logic             len_zero;
    logic [LEN_W-1:0] len_val;
    logic             last_bit;

    assign loading = st_is_loading(st_q);
    assign clr     = (st_q == LD_START);

    cfg_clk_gen #(
        .DIV_LOG2 (DIV_LOG2)
    ) clk_gen_i (
        .clk       (clk),
        .rst       (rst),
        .run_i     (loading),
        .kill_i    (abort_i),
        .cfg_clk_o (cfg_clk_o),
        .sample_o  (sample)
    );

    cfg_header_parser #(
        .PRE_W      (PRE_W),
        .PREAMBLE   (PREAMBLE),
        .LEN_W      (LEN_W),
        .HUNT_LIMIT (HUNT_LIMIT)
    ) hdr_i (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (clr),
        .sample_i   (sample),
        .bit_i      (ser_din_i),
        .hunt_i     (st_q == LD_HUNT),
        .len_i      (st_q == LD_LEN),
        .pre_hit_o  (pre_hit),
        .hunt_exp_o (hunt_exp),
        .len_done_o (len_done),
        .len_zero_o (len_zero),
        .len_val_o  (len_val)
    );

    cfg_frame_packer #(
        .FRAME_W (FRAME_W),
        .LEN_W   (LEN_W)
    ) pack_i (
        .clk           (clk),
        .rst           (rst),
        .clr_i         (clr),
        .sample_i      (sample && (st_q == LD_DATA)),
        .bit_i         (ser_din_i),
        .total_i       (len_val),
        .last_o        (last_bit),
        .frame_data_o  (frame_data_o),
        .frame_valid_o (frame_valid_o)
    );

    always_comb begin
        st_next = st_q;
        if (abort_i) begin
            st_next = LD_START;
        end else begin
            unique case (st_q)
                LD_START: st_next = (mode_i == MASTER_SERIAL_MODE) ? LD_HUNT : LD_OFF;
                LD_HUNT: begin
                    if (pre_hit)       st_next = LD_LEN;
                    else if (hunt_exp) st_next = LD_ERR;
                end
                LD_LEN: begin
                    if (len_done) st_next = len_zero ? LD_DONE : LD_DATA;
                end
                LD_DATA: begin
                    if (last_bit) st_next = LD_DONE;
                end
                LD_OFF, LD_DONE, LD_ERR: begin
                    if (done_pull_i) st_next = LD_START;
                end
                default: st_next = LD_START;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LD_START;
        else     st_q <= st_next;
    end

    assign done_o     = (st_q == LD_DONE);
    assign load_err_o = (st_q == LD_ERR);

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
    parameter int FRAME_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [2:0]         mode_i,
    input logic               abort_i,
    input logic               done_pull_i,
    input logic               ser_din_i,
    input logic               cfg_clk_o,
    input logic               done_o,
    input logic               load_err_o,
    input logic [FRAME_W-1:0] frame_data_o,
    input logic               frame_valid_o
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst_q |-> (!done_o && !load_err_o && !frame_valid_o && !cfg_clk_o));

    // R3
    clk_high_two_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cfg_clk_o) && !abort_i) |=> cfg_clk_o);

    // R5
    no_clk_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !$rose(cfg_clk_o));

    // R6
    frame_single_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid_o |=> !frame_valid_o);

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !done_pull_i && !abort_i) |=> done_o);

    // R10
    err_no_clk_chk: assert property (@(posedge clk) disable iff (rst)
        load_err_o |=> !$rose(cfg_clk_o));

    // R10
    err_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && load_err_o));

    // R9
    pull_drops_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && done_pull_i) |=> !done_o);

    logic unused_ok;
    assign unused_ok = ^{mode_i, ser_din_i, frame_data_o};

endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(.FRAME_W(FRAME_W)) chk_i (.*);

// File: tb/cfg_serial_loader_tb.sv
`timescale 1ns/1ps
module cfg_serial_loader_tb_top;
    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    mode;
    logic          abort_r;
    logic          pull_r;
    logic          ser_din;
    logic          cfg_clk;
    logic          done;
    logic          err;
    logic [FW-1:0] fdata;
    logic          fvalid;

    always #2.5 clk = ~clk;

    cfg_serial_loader dut_i (
        .clk           (clk),
        .rst           (rst),
        .mode_i        (mode),
        .abort_i       (abort_r),
        .done_pull_i   (pull_r),
        .ser_din_i     (ser_din),
        .cfg_clk_o     (cfg_clk),
        .done_o        (done),
        .load_err_o    (err),
        .frame_data_o  (fdata),
        .frame_valid_o (fvalid)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int pulses = 0;
    int base = 0;
    int first_rise = 0;
    int last_rise = 0;
    int slen = 0;
    int nf = 0;
    int fbase = 0;
    bit stream_q [0:1023];
    logic [FW-1:0] got [0:1023];

    always @(posedge clk) cyc <= cyc + 1;

    // Serial memory model: advances one bit per configuration clock edge.
    always @(posedge cfg_clk) begin
        if (pulses == base) first_rise <= cyc;
        last_rise <= cyc;
        pulses <= pulses + 1;
    end

    assign ser_din = (pulses >= base && (pulses - base) < slen) ?
                     stream_q[pulses - base] : 1'b1;

    always @(negedge clk) begin
        if (fvalid) begin
            got[nf] <= fdata;
            nf <= nf + 1;
        end
    end

    function automatic bit dbit(int i, int seed);
        return ((i * 13 + seed * 7 + (i >> 2)) % 5) < 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(bit b);
        stream_q[slen] = b;
        slen++;
    endtask

    task automatic build(int k, int len, int seed, bit junk);
        slen = 0;
        if (junk) begin
            push(1); push(1); push(0); push(1);
        end
        for (int i = 0; i < k; i++) push(1);
        for (int i = 7; i >= 0; i--) push(((8'hF2 >> i) & 1) != 0);
        for (int i = 23; i >= 0; i--) push(((len >> i) & 1) != 0);
        for (int i = 0; i < len; i++) push(dbit(i, seed));
    endtask

    task automatic arm();
        base = pulses;
        fbase = nf;
    endtask

    task automatic start_by_pull();
        @(negedge clk);
        arm();
        pull_r = 1'b1;
        @(negedge clk);
        pull_r = 1'b0;
        check("R9 done low after pull", int'(done), 0);
        check("R10 error cleared by pull", int'(err), 0);
    endtask

    task automatic wait_end();
        int n = 0;
        while (!done && !err && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic verify(int len, int seed, string tag);
        int nexp;
        int p;
        check({tag, " done high"}, int'(done), 1);
        check({tag, " no error"}, int'(err), 0);
        p = pulses - base;
        check({tag, " R5 edge count"}, p, slen);
        if (p > 1) check({tag, " R3 edge spacing"}, last_rise - first_rise, 4 * (p - 1));
        nexp = (len + FW - 1) / FW;
        check({tag, " R6 word count"}, nf - fbase, nexp);
        for (int j = 0; j < nexp && j < nf - fbase; j++) begin
            int lo = j * FW;
            int n = (len - lo < FW) ? len - lo : FW;
            int e = 0;
            for (int b = 0; b < n; b++) e = (e << 1) | int'(dbit(lo + b, seed));
            check({tag, " R6 word value"}, int'(got[fbase + j]), e);
        end
        repeat (30) @(negedge clk);
        check({tag, " R7 done held"}, int'(done), 1);
        check({tag, " R5 no extra edge"}, pulses - base, p);
    endtask

    task automatic abort_at(int at_bit);
        int n = 0;
        while ((pulses - base) < at_bit && n < 20000) begin
            @(negedge clk);
            n++;
        end
        abort_r = 1'b1;
        @(negedge clk);
        abort_r = 1'b0;
        arm();
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        mode = 3'b000;
        abort_r = 1'b0;
        pull_r = 1'b0;
        build(5, 12, 1, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 done at reset", int'(done), 0);
        check("R1 cfg_clk at reset", int'(cfg_clk), 0);
        check("R1 error at reset", int'(err), 0);
        check("R1 valid at reset", int'(fvalid), 0);
        arm();
        rst = 1'b0;
        wait_end();
        verify(12, 1, "R1 first load");

        // Sweep payload length over every remainder modulo the word size.
        for (int len = 0; len <= 20; len++) begin
            build(3, len, len, 1'b0);
            start_by_pull();
            wait_end();
            verify(len, len, (len == 0) ? "R7 zero length" : "R6 sweep");
        end

        // R4: filler containing zeros before the sync pattern.
        build(2, 9, 4, 1'b1);
        start_by_pull();
        wait_end();
        verify(9, 4, "R4 junk prefix");

        // R4: sync pattern completes on the last permitted bit.
        build(56, 7, 8, 1'b0);
        start_by_pull();
        wait_end();
        verify(7, 8, "R4 window edge");

        // R10: sync pattern completes one bit too late.
        build(57, 8, 2, 1'b0);
        start_by_pull();
        wait_end();
        check("R10 error flag", int'(err), 1);
        check("R10 done low", int'(done), 0);
        check("R10 edge count", pulses - base, 64);

        build(1, 5, 3, 1'b0);
        start_by_pull();
        wait_end();
        verify(5, 3, "R10 recovery");

        // R2: every non-zero mode keeps the loader quiet.
        for (int m = 1; m < 8; m++) begin
            mode = 3'(m);
            build(2, 6, m, 1'b0);
            start_by_pull();
            repeat (100) @(negedge clk);
            check("R2 no clock in other mode", pulses - base, 0);
            check("R2 done stays low", int'(done), 0);
        end
        mode = 3'b000;
        build(2, 10, 5, 1'b0);
        start_by_pull();
        wait_end();
        verify(10, 5, "R2 mode restored");

        // R8: abort inside the header, then inside a half-built word.
        build(3, 40, 6, 1'b0);
        start_by_pull();
        abort_at(20);
        wait_end();
        verify(40, 6, "R8 abort in header");

        build(3, 40, 9, 1'b0);
        start_by_pull();
        abort_at(50);
        wait_end();
        verify(40, 9, "R8 abort in payload");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule